// File: doc/BRIEF.md
# Peripheral Access Wait-State Generator

This block decides how many extra processor wait cycles are inserted when instructions touch the sound chip's I/O window, and it produces the stall itself. For each access it receives a pulse, a marker saying whether the access opens a new instruction, a flag for multi-register block moves, a flag for the write half of a read-modify-write, and two attributes of the address: whether a shadow alias was used and whether the access was byte-sized. Address decoding and the register file live elsewhere.

The wait is charged once per instruction, not once per access. Block moves are the exception: every fourth further access charges another wait. Each charged wait holds the ready output low for a fixed number of clock cycles. Charges that arrive while a stall is already running are queued in a small saturating counter, and they play out with no gap between them.

Top module: `psg_wait_gen`

## Requirements
- R1: During reset and directly after it, ready is 1 and no stall is pending.
- R2: An accepted access with new_instr=1 charges one wait. When the block is idle, ready goes low in the following cycle and stays low for exactly WAIT_CYC cycles (default 4).
- R3: An accepted access with new_instr=0, block_move=0 and rmw_write=0 charges nothing. A four-register transfer therefore costs one wait in total.
- R4: In a block move, each accepted further access (new_instr=0, block_move=1, rmw_write=0) advances a per-instruction counter. Every GROUP-th such access (default 4th, 8th, 12th...) charges another wait.
- R5: An accepted access with new_instr=1 clears the per-instruction counter, so further accesses left over from an earlier instruction do not count toward the next charge.
- R6: An access with acc_shadow=1 and acc_byte=0 is ignored. It charges no wait and leaves the counter unchanged. A byte-sized shadow access is accepted like any other.
- R7: An accepted access with rmw_write=1 charges its own wait even inside the same instruction, so a read followed by its read-modify-write store costs two waits (8 cycles by default).
- R8: Charges that arrive during a stall are queued. Their stalls follow one another with ready held low continuously. Ready goes high only when nothing is queued.
- R9: At most 2**PEND_W-1 charges can be queued behind the running stall. A charge that arrives while the queue is full and the running stall has more than one cycle left is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One access to the sound chip window in this cycle |
| acc_shadow | input | 1 | The access used the odd shadow alias |
| acc_byte | input | 1 | The access is byte-sized (or a peripheral byte move) |
| new_instr | input | 1 | The access is the first one made by a new instruction |
| block_move | input | 1 | The instruction is a multi-register block move |
| rmw_write | input | 1 | The access is the store half of a read-modify-write |
| ready | output | 1 | Low while the bus is stalled |

## Verification
The bench builds the block with WAIT_CYC=4 and GROUP=4, the measured values, and with PEND_W=2. A queue limit of three means a burst of six instruction starts on consecutive cycles fills the queue and drops a charge, so the saturation edge is reached within a few cycles. Long block moves of up to sixteen accesses exercise the group counter wrap several times. The random phase mixes shadow, rmw and new-instruction flags, which lets a queued charge meet the final cycle of a running stall.

// File: rtl/psg_wait_gen.sv
module psg_wait_gen #(
  parameter int WAIT_CYC = 4,
  parameter int GROUP    = 4,
  parameter int PEND_W   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic acc_shadow,
  input  logic acc_byte,
  input  logic new_instr,
  input  logic block_move,
  input  logic rmw_write,
  output logic ready
);
  localparam int TW   = $clog2(WAIT_CYC + 1);
  localparam int GW   = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam int PMAX = (1 << PEND_W) - 1;

  logic [TW-1:0]     timer;
  logic [PEND_W-1:0] pend;
  logic [GW-1:0]     grp;
  logic [PEND_W:0]   total;

  wire accept   = acc_valid & (~acc_shadow | acc_byte);
  wire grp_last = (grp == GW'(GROUP - 1));
  wire further  = accept & ~new_instr & block_move & ~rmw_write;
  wire charge   = accept & (new_instr | rmw_write | (further & grp_last));
  wire done     = (timer <= TW'(1));

  assign total = {1'b0, pend} + {{PEND_W{1'b0}}, charge};
  assign ready = (timer == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      grp <= '0;
    else if (accept & new_instr)
      grp <= '0;
    else if (further)
      grp <= grp_last ? '0 : grp + GW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer <= '0;
      pend  <= '0;
    end else if (done) begin
      if (total != '0) begin
        timer <= TW'(WAIT_CYC);
        pend  <= PEND_W'(total - 1'b1);
      end else begin
        timer <= '0;
        pend  <= '0;
      end
    end else begin
      timer <= timer - TW'(1);
      pend  <= (total > (PEND_W+1)'(PMAX)) ? PEND_W'(PMAX) : PEND_W'(total);
    end
  end

  assert_idle_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (pend == '0));

  assert_first_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (!acc_shadow || acc_byte) && new_instr && ready) |=> !ready);

  assert_ignored_shadow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_shadow && !acc_byte && ready) |=> ready);

  assert_no_extra_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !new_instr && !block_move && !rmw_write && ready) |=> ready);

  assert_gapless_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(pend) == '0));
endmodule

// File: tb/sim_psg_wait_gen.sv
module sim_psg_wait_gen;
  localparam int WAIT_CYC = 4;
  localparam int GROUP    = 4;
  localparam int PEND_W   = 2;
  localparam int PMAX     = (1 << PEND_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_shadow = 0, acc_byte = 0;
  logic new_instr = 0, block_move = 0, rmw_write = 0;
  logic ready;

  int checks = 0, failures = 0;
  int owed = 0, grp = 0, low_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  psg_wait_gen #(.WAIT_CYC(WAIT_CYC), .GROUP(GROUP), .PEND_W(PEND_W)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_shadow(acc_shadow),
    .acc_byte(acc_byte), .new_instr(new_instr), .block_move(block_move),
    .rmw_write(rmw_write), .ready(ready));

  function automatic bit model_charge(bit v, bit sh, bit by, bit ni, bit bm, bit rw);
    bit acc = v && (!sh || by);
    return acc && (ni || rw || (bm && grp == GROUP - 1));
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(bit v, bit sh, bit by, bit ni, bit bm, bit rw, string tag);
    bit acc, ch;
    int base;
    acc_valid = v; acc_shadow = sh; acc_byte = by;
    new_instr = ni; block_move = bm; rmw_write = rw;
    acc = v && (!sh || by);
    ch = model_charge(v, sh, by, ni, bm, rw);
    @(posedge clk);
    base = (owed > 0) ? owed - 1 : 0;
    if (ch && base <= WAIT_CYC * PMAX) base += WAIT_CYC;
    owed = base;
    if (acc && ni) grp = 0;
    else if (acc && bm && !rw) grp = (grp == GROUP - 1) ? 0 : grp + 1;
    @(negedge clk);
    chk(ready == (owed == 0), tag, ready, owed == 0);
    if (!ready) low_cnt++;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic expect_low(int exp, string tag);
    idle(30, tag);
    chk(low_cnt == exp, tag, low_cnt, exp);
    low_cnt = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1", ready, 1);
    rst_n = 1'b1;
    idle(3, "R1");
    low_cnt = 0;

    // R2: single byte move starts one stall of WAIT_CYC cycles
    cyc(1, 0, 1, 1, 0, 0, "R2");
    expect_low(WAIT_CYC, "R2");

    // R3: four registers touched by one instruction, one wait only
    cyc(1, 0, 1, 1, 0, 0, "R3");
    cyc(1, 0, 1, 0, 0, 0, "R3");
    cyc(1, 0, 1, 0, 0, 0, "R3");
    cyc(1, 0, 1, 0, 0, 0, "R3");
    expect_low(WAIT_CYC, "R3");

    // R4: block move of 8 accesses -> charges at first and 4th further
    cyc(1, 0, 0, 1, 1, 0, "R4");
    for (int i = 0; i < 7; i++) cyc(1, 0, 0, 0, 1, 0, "R4");
    expect_low(2 * WAIT_CYC, "R4");

    // R4: block move of 16 accesses -> four charges
    cyc(1, 0, 0, 1, 1, 0, "R4");
    for (int i = 0; i < 15; i++) cyc(1, 0, 0, 0, 1, 0, "R4");
    expect_low(4 * WAIT_CYC, "R4");

    // R5: counter restarts at each new instruction
    cyc(1, 0, 0, 1, 1, 0, "R5");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 1, 0, "R5");
    cyc(1, 0, 0, 1, 1, 0, "R5");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 1, 0, "R5");
    expect_low(2 * WAIT_CYC, "R5");

    // R6: non-byte shadow access ignored; byte shadow accepted
    cyc(1, 1, 0, 1, 0, 0, "R6");
    expect_low(0, "R6");
    cyc(1, 1, 1, 1, 0, 0, "R6");
    expect_low(WAIT_CYC, "R6");
    // R6: ignored shadow accesses do not advance the group counter
    cyc(1, 0, 0, 1, 1, 0, "R6");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 1, 0, "R6");
    cyc(1, 1, 0, 0, 1, 0, "R6");
    expect_low(WAIT_CYC, "R6");

    // R7: read then read-modify-write store -> two waits
    cyc(1, 0, 1, 1, 0, 0, "R7");
    cyc(1, 0, 1, 0, 0, 1, "R7");
    expect_low(2 * WAIT_CYC, "R7");

    // R8: charge landing on the final stall cycle continues without gap
    cyc(1, 0, 1, 1, 0, 0, "R8");
    idle(WAIT_CYC - 1, "R8");
    cyc(1, 0, 1, 1, 0, 0, "R8");
    expect_low(2 * WAIT_CYC, "R8");

    // R9: six starts in a row with a queue of three -> one dropped
    for (int i = 0; i < 6; i++) cyc(1, 0, 1, 1, 0, 0, "R9");
    expect_low(5 * WAIT_CYC, "R9");

    // R8: random mix checked every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      bit v  = ($urandom % 3) != 0;
      bit sh = ($urandom % 4) == 0;
      bit by = ($urandom % 2) == 0;
      bit ni = ($urandom % 5) == 0;
      bit bm = ($urandom % 2) == 0;
      bit rw = ($urandom % 12) == 0;
      cyc(v, sh, by, ni, bm, rw, "R8");
    end
    idle(40, "R8");
    chk(ready == 1'b1, "R8", ready, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule